// File: doc/BRIEF.md
# USB Device Endpoint Control and Status Register File

This block holds the software-visible control and status state of a USB device controller. Through a simple word-addressed read/write port, software sets the device address and the per-endpoint enables, and it arms (primes) transfers. It also reads and acknowledges the setup-received, transfer-complete and device status bits, and it controls the run/stop bit and a controller reset. The port logic and the transfer engine are outside the block. They report to it through single-cycle strobes: bus reset detected, suspend, port change, setup received and transfer done. They also supply two level inputs: high-speed port and reset active.

When the port logic detects a bus reset, the block does the hardware part of the cleanup by itself. The address returns to 0, every endpoint except endpoint 0 is disabled, and all primed transfers are cancelled. Software then acknowledges the setup and complete bits by writing back the values it read. It cancels any remaining primes with a flush mask. It can confirm that the reset is still in progress by reading the reset-active bit. One interrupt line is driven high while any status bit is set together with its enable.

Word map (4-bit word address): 0 control (bit 0 run, bit 1 controller reset), 1 status, 2 interrupt enable, 3 device address, 4 endpoint enable, 5 setup received, 6 prime, 7 flush, 8 complete. Addresses 9 to 15 read 0. In the prime, flush and complete words, receive-direction endpoint n is bit n and transmit-direction endpoint n is bit 16+n.

Top module: `usbd_ep_regs`

## Requirements
- R1: A cycle with bus_reset_det high forces the device address (word 3, bits [6:0]) to 0, even if a software write to it happens in the same cycle.
- R2: A bus reset clears every endpoint enable bit (word 4) except bit 0, which keeps its value, and clears every prime bit (word 6).
- R3: A bus reset sets status bit 1. The irq output goes high for it only when interrupt-enable bit 1 is set.
- R4: Setup-received bits (word 5, bit n set by setup_rcvd[n]) and complete bits (word 8) are write-one-to-clear. Writing back a value that was read clears exactly those bits. Bits written as 0 keep their value.
- R5: A write to word 7 clears each prime bit whose mask bit is 1, so an all-ones mask cancels every prime. Word 7 always reads 0. A write of ones to word 6 sets prime bits.
- R6: Writing 1 to control bit 1 resets the block on the following cycle. Run/stop goes to 0 (detaching the device), the address, interrupt enables, status, setup, prime and complete bits go to 0, and the endpoint enables go to 0x0001. The reset bit then reads 0 again.
- R7: Status bits 0 (suspend), 1 (bus reset) and 2 (port change) are set by their strobes and are write-one-to-clear. Bit 8 shows port_hs and bit 9 shows port_reset_act live. Writes do not change bits 8 and 9, and these two bits never raise irq.
- R8: irq is registered. It is high one cycle after any of status bits [2:0] is set together with the same bit of word 2, and it is low when no such pair exists.
- R9: If a transfer-done strobe and a software write-one-to-clear hit the same complete bit in the same cycle, the bit ends up set.
- R10: xfer_done[i] sets complete bit i and clears prime bit i. Here i is n for receive endpoint n and 16+n for transmit endpoint n.
- R11: reg_rdata shows the addressed word one cycle after reg_rd, and an unmapped address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after reg_rd |
| bus_reset_det | input | 1 | Bus reset detected strobe |
| port_reset_act | input | 1 | Bus reset currently in progress (level) |
| port_hs | input | 1 | Port attached at high speed (level) |
| suspend_det | input | 1 | Suspend entered strobe |
| port_change_det | input | 1 | Port change strobe |
| setup_rcvd | input | NUM_EP | Setup packet received, per endpoint |
| xfer_done | input | 2*NUM_EP | Transfer done, {transmit, receive} per endpoint |
| run_stop | output | 1 | Run/stop bit, attaches the device when high |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a transfer-done strobe and a software write-one-to-clear landing on the same complete bit in the same clock. The stimulus reaches it by driving the write and the xfer_done strobe on the same falling edge, so that one rising edge samples both. The bus-reset cleanup is checked while several endpoints are enabled and both directions are primed, with the reset-active level held, so that each forced clear can be seen in a read. The controller reset is checked by reading every word after the self-clearing cycle has passed.

// File: rtl/usbd_ep_pkg.sv
package usbd_ep_pkg;
  localparam int REG_AW   = 4;
  localparam int WORD_W   = 32;
  localparam int TX_BASE  = 16;
  localparam int DEVA_W   = 7;
  localparam int NSTAT    = 3;

  typedef enum logic [REG_AW-1:0] {
    RA_CTRL  = 4'd0,
    RA_STAT  = 4'd1,
    RA_IEN   = 4'd2,
    RA_ADDR  = 4'd3,
    RA_EPEN  = 4'd4,
    RA_SETUP = 4'd5,
    RA_PRIME = 4'd6,
    RA_FLUSH = 4'd7,
    RA_CMPL  = 4'd8
  } reg_addr_e;

  localparam int ST_HS_BIT  = 8;
  localparam int ST_RST_BIT = 9;
endpackage

// File: rtl/usbd_w1c_bank.sv
module usbd_w1c_bank #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_all,
  input  logic [W-1:0] hw_set,
  input  logic         sw_wr,
  input  logic [W-1:0] sw_mask,
  output logic [W-1:0] q
);
  logic [W-1:0] ack;
  assign ack = sw_wr ? sw_mask : '0;

  // hardware set is ORed in after the acknowledge so that it wins
  always_ff @(posedge clk) begin
    if (rst || clr_all) q <= '0;
    else                q <= (q & ~ack) | hw_set;
  end
endmodule

// File: rtl/usbd_prime_bank.sv
module usbd_prime_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_all,
  input  logic         arm_wr,
  input  logic [W-1:0] arm_mask,
  input  logic         flush_wr,
  input  logic [W-1:0] flush_mask,
  input  logic [W-1:0] done,
  output logic [W-1:0] q
);
  logic [W-1:0] arm, drop;
  assign arm  = arm_wr ? arm_mask : '0;
  assign drop = done | (flush_wr ? flush_mask : '0);

  always_ff @(posedge clk) begin
    if (rst || clr_all) q <= '0;
    else                q <= (q & ~drop) | arm;
  end
endmodule

// File: rtl/usbd_rd_mux.sv
module usbd_rd_mux
  import usbd_ep_pkg::*;
#(
  parameter int NUM_EP = 16,
  localparam int DIR_W = 2 * NUM_EP
) (
  input  logic [REG_AW-1:0] addr,
  input  logic              run,
  input  logic              soft_rst,
  input  logic [NSTAT-1:0]  stat,
  input  logic              hs,
  input  logic              rst_act,
  input  logic [NSTAT-1:0]  ien,
  input  logic [DEVA_W-1:0] devaddr,
  input  logic [NUM_EP-1:0] epen,
  input  logic [NUM_EP-1:0] setup,
  input  logic [DIR_W-1:0]  prime,
  input  logic [DIR_W-1:0]  cmpl,
  output logic [WORD_W-1:0] word
);
  function automatic logic [WORD_W-1:0] spread(input logic [DIR_W-1:0] v);
    logic [WORD_W-1:0] r;
    r = '0;
    r[NUM_EP-1:0]         = v[NUM_EP-1:0];
    r[TX_BASE +: NUM_EP]  = v[DIR_W-1:NUM_EP];
    return r;
  endfunction

  always_comb begin
    word = '0;
    case (addr)
      RA_CTRL:  word[1:0] = {soft_rst, run};
      RA_STAT: begin
        word[NSTAT-1:0]  = stat;
        word[ST_HS_BIT]  = hs;
        word[ST_RST_BIT] = rst_act;
      end
      RA_IEN:   word[NSTAT-1:0]  = ien;
      RA_ADDR:  word[DEVA_W-1:0] = devaddr;
      RA_EPEN:  word[NUM_EP-1:0] = epen;
      RA_SETUP: word[NUM_EP-1:0] = setup;
      RA_PRIME: word = spread(prime);
      RA_CMPL:  word = spread(cmpl);
      default:  word = '0;
    endcase
  end
endmodule

// File: rtl/usbd_ep_regs.sv
module usbd_ep_regs
  import usbd_ep_pkg::*;
#(
  parameter int NUM_EP = 16,
  localparam int DIR_W = 2 * NUM_EP
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              bus_reset_det,
  input  logic              port_reset_act,
  input  logic              port_hs,
  input  logic              suspend_det,
  input  logic              port_change_det,
  input  logic [NUM_EP-1:0] setup_rcvd,
  input  logic [DIR_W-1:0]  xfer_done,
  output logic              run_stop,
  output logic              irq
);
  localparam logic [NUM_EP-1:0] EP0_ONLY = NUM_EP'(1);

  logic              soft_rst_q, run_q;
  logic [NSTAT-1:0]  ien_q, stat_q;
  logic [DEVA_W-1:0] addr_q;
  logic [NUM_EP-1:0] epen_q, setup_q;
  logic [DIR_W-1:0]  prime_q, cmpl_q, wdir;
  logic [WORD_W-1:0] rd_word;
  logic              wr_ctrl, wr_stat, wr_ien, wr_addr, wr_epen;
  logic              wr_setup, wr_prime, wr_flush, wr_cmpl;

  assign wr_ctrl  = reg_wr && (reg_addr == RA_CTRL);
  assign wr_stat  = reg_wr && (reg_addr == RA_STAT);
  assign wr_ien   = reg_wr && (reg_addr == RA_IEN);
  assign wr_addr  = reg_wr && (reg_addr == RA_ADDR);
  assign wr_epen  = reg_wr && (reg_addr == RA_EPEN);
  assign wr_setup = reg_wr && (reg_addr == RA_SETUP);
  assign wr_prime = reg_wr && (reg_addr == RA_PRIME);
  assign wr_flush = reg_wr && (reg_addr == RA_FLUSH);
  assign wr_cmpl  = reg_wr && (reg_addr == RA_CMPL);

  // receive bits from the low half, transmit bits from the upper half
  assign wdir = {reg_wdata[TX_BASE +: NUM_EP], reg_wdata[NUM_EP-1:0]};

  always_ff @(posedge clk) begin
    if (rst || soft_rst_q) begin
      run_q      <= 1'b0;
      soft_rst_q <= 1'b0;
      ien_q      <= '0;
      addr_q     <= '0;
      epen_q     <= EP0_ONLY;
    end else begin
      if (wr_ctrl) begin
        run_q      <= reg_wdata[0];
        soft_rst_q <= reg_wdata[1];
      end
      if (wr_ien)  ien_q  <= reg_wdata[NSTAT-1:0];
      if (wr_addr) addr_q <= reg_wdata[DEVA_W-1:0];
      if (wr_epen) epen_q <= reg_wdata[NUM_EP-1:0];
      if (bus_reset_det) begin
        addr_q <= '0;
        epen_q <= (wr_epen ? reg_wdata[NUM_EP-1:0] : epen_q) & EP0_ONLY;
      end
    end
  end

  usbd_w1c_bank #(.W(NSTAT)) u_stat (
    .clk(clk), .rst(rst), .clr_all(soft_rst_q),
    .hw_set({port_change_det, bus_reset_det, suspend_det}),
    .sw_wr(wr_stat), .sw_mask(reg_wdata[NSTAT-1:0]), .q(stat_q)
  );

  usbd_w1c_bank #(.W(NUM_EP)) u_setup (
    .clk(clk), .rst(rst), .clr_all(soft_rst_q),
    .hw_set(setup_rcvd), .sw_wr(wr_setup),
    .sw_mask(reg_wdata[NUM_EP-1:0]), .q(setup_q)
  );

  usbd_w1c_bank #(.W(DIR_W)) u_cmpl (
    .clk(clk), .rst(rst), .clr_all(soft_rst_q),
    .hw_set(xfer_done), .sw_wr(wr_cmpl), .sw_mask(wdir), .q(cmpl_q)
  );

  usbd_prime_bank #(.W(DIR_W)) u_prime (
    .clk(clk), .rst(rst), .clr_all(soft_rst_q || bus_reset_det),
    .arm_wr(wr_prime), .arm_mask(wdir),
    .flush_wr(wr_flush), .flush_mask(wdir),
    .done(xfer_done), .q(prime_q)
  );

  usbd_rd_mux #(.NUM_EP(NUM_EP)) u_mux (
    .addr(reg_addr), .run(run_q), .soft_rst(soft_rst_q),
    .stat(stat_q), .hs(port_hs), .rst_act(port_reset_act),
    .ien(ien_q), .devaddr(addr_q), .epen(epen_q), .setup(setup_q),
    .prime(prime_q), .cmpl(cmpl_q), .word(rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (reg_rd) reg_rdata <= rd_word;
      irq <= soft_rst_q ? 1'b0 : |(stat_q & ien_q);
    end
  end

  assign run_stop = run_q;
endmodule

// File: rtl/usbd_ep_regs_chk.sv
module usbd_ep_regs_chk #(
  parameter int NUM_EP = 16,
  localparam int DIR_W = 2 * NUM_EP
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic              bus_reset_det,
  input logic [DIR_W-1:0]  xfer_done,
  input logic              soft_rst_q,
  input logic              run_q,
  input logic [6:0]        addr_q,
  input logic [NUM_EP-1:0] epen_q,
  input logic [DIR_W-1:0]  prime_q,
  input logic [DIR_W-1:0]  cmpl_q,
  input logic [2:0]        ien_q,
  input logic              irq
);
  // R1
  a_r1_addr_zero: assert property (@(posedge clk) disable iff (rst)
    bus_reset_det |=> (addr_q == '0));
  // R2
  a_r2_ep_off: assert property (@(posedge clk) disable iff (rst)
    bus_reset_det |=> ((epen_q >> 1) == '0));
  // R2
  a_r2_prime_off: assert property (@(posedge clk) disable iff (rst)
    bus_reset_det |=> (prime_q == '0));
  // R6
  a_r6_rst_selfclr: assert property (@(posedge clk) disable iff (rst)
    soft_rst_q |=> (!soft_rst_q && !run_q && addr_q == '0 && cmpl_q == '0));
  // R9
  a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
    (xfer_done != '0 && !soft_rst_q) |=> ((cmpl_q & $past(xfer_done)) == $past(xfer_done)));
  // R10
  a_r10_prime_drop: assert property (@(posedge clk) disable iff (rst)
    (xfer_done != '0 && !reg_wr) |=> ((prime_q & $past(xfer_done)) == '0));
  // R8
  a_r8_irq_masked: assert property (@(posedge clk) disable iff (rst)
    (ien_q == '0) |=> !irq);
endmodule

bind usbd_ep_regs usbd_ep_regs_chk #(.NUM_EP(NUM_EP)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .bus_reset_det(bus_reset_det),
  .xfer_done(xfer_done), .soft_rst_q(soft_rst_q), .run_q(run_q),
  .addr_q(addr_q), .epen_q(epen_q), .prime_q(prime_q), .cmpl_q(cmpl_q),
  .ien_q(ien_q), .irq(irq)
);

// File: tb/usbd_ep_regs_bench.sv
module usbd_ep_regs_bench;
  localparam int NE = 16;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        bus_reset_det = 1'b0, port_reset_act = 1'b0, port_hs = 1'b0;
  logic        suspend_det = 1'b0, port_change_det = 1'b0;
  logic [NE-1:0]   setup_rcvd = '0;
  logic [2*NE-1:0] xfer_done = '0;
  logic        run_stop, irq;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;
  bit mon_pend = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  usbd_ep_regs u_usbd_ep_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bus_reset_det(bus_reset_det), .port_reset_act(port_reset_act),
    .port_hs(port_hs), .suspend_det(suspend_det),
    .port_change_det(port_change_det), .setup_rcvd(setup_rcvd),
    .xfer_done(xfer_done), .run_stop(run_stop), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // driver: pushes the expected word, the monitor compares it
  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    reg_rd = 1'b0; mon_pend = 1'b1;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    @(negedge clk);
    #2 check(tag, {31'b0, irq}, {31'b0, e});
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #1;
      if (mon_pend) begin
        mon_pend = 1'b0;
        check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin : watchdog
    #(20 * 100000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // reset state (R6, R8, R11)
    rd(4'd0, 32'h0, "R6 reset ctrl");
    rd(4'd4, 32'h1, "R6 reset epen");
    rd(4'd3, 32'h0, "R6 reset addr");
    chk_irq(1'b0, "R8 reset irq");

    wr(4'd0, 32'h1);
    wr(4'd3, 32'h2A);
    wr(4'd4, 32'hFFFF);
    wr(4'd6, 32'hFFFF_FFFF);
    wr(4'd2, 32'h2);
    rd(4'd0, 32'h1, "R11 ctrl run");
    rd(4'd3, 32'h2A, "R11 addr");
    rd(4'd6, 32'hFFFF_FFFF, "R5 prime set");
    check("R6 run_stop pin", {31'b0, run_stop}, 32'h1);

    // R10 transfer done: rx ep1, tx ep0
    @(negedge clk); xfer_done = 32'h0001_0002;
    @(negedge clk); xfer_done = '0;
    rd(4'd6, 32'hFFFE_FFFD, "R10 prime cleared");
    rd(4'd8, 32'h0001_0002, "R10 complete set");

    // R4 setup write-one-to-clear
    @(negedge clk); setup_rcvd = 16'h0005;
    @(negedge clk); setup_rcvd = '0;
    rd(4'd5, 32'h5, "R4 setup set");
    wr(4'd5, 32'h1);
    rd(4'd5, 32'h4, "R4 setup partial clear");
    wr(4'd5, 32'h4);
    rd(4'd5, 32'h0, "R4 setup writeback");

    // R9 set and clear in the same cycle
    @(negedge clk);
    xfer_done = 32'h10; reg_wr = 1'b1; reg_addr = 4'd8; reg_wdata = 32'h10;
    @(negedge clk);
    xfer_done = '0; reg_wr = 1'b0;
    rd(4'd8, 32'h0001_0012, "R9 set wins");
    wr(4'd8, 32'h0001_0012);
    rd(4'd8, 32'h0, "R4 complete writeback");

    // R5 flush
    wr(4'd7, 32'h0000_00FF);
    rd(4'd6, 32'hFFFE_FF00, "R5 partial flush");
    rd(4'd7, 32'h0, "R5 flush reads zero");
    wr(4'd7, 32'hFFFF_FFFF);
    rd(4'd6, 32'h0, "R5 full flush");

    // bus reset (R1, R2, R3, R7)
    wr(4'd6, 32'h0003_0003);
    port_reset_act = 1'b1;
    @(negedge clk); bus_reset_det = 1'b1;
    @(negedge clk); bus_reset_det = 1'b0;
    chk_irq(1'b1, "R3 irq on bus reset");
    rd(4'd3, 32'h0, "R1 addr cleared");
    rd(4'd4, 32'h1, "R2 ep0 kept others off");
    rd(4'd6, 32'h0, "R2 primes cancelled");
    rd(4'd1, 32'h202, "R7 status and reset active");
    rd(4'd0, 32'h1, "R2 run unaffected");
    port_reset_act = 1'b0;
    wr(4'd1, 32'h2);
    rd(4'd1, 32'h0, "R7 status w1c");
    chk_irq(1'b0, "R8 irq drops");

    // masked interrupts and read-only bits (R3, R7, R8)
    wr(4'd2, 32'h0);
    @(negedge clk); suspend_det = 1'b1;
    @(negedge clk); suspend_det = 1'b0;
    port_hs = 1'b1;
    chk_irq(1'b0, "R8 masked suspend");
    chk_irq(1'b0, "R7 hs no irq");
    rd(4'd1, 32'h101, "R7 suspend and hs");
    wr(4'd2, 32'h7);
    chk_irq(1'b1, "R8 enabled irq");
    @(negedge clk); port_change_det = 1'b1;
    @(negedge clk); port_change_det = 1'b0;
    rd(4'd1, 32'h105, "R7 port change");
    wr(4'd1, 32'h105);
    rd(4'd1, 32'h100, "R7 hs read only");
    chk_irq(1'b0, "R8 irq cleared");

    // R1 write racing bus reset
    @(negedge clk);
    bus_reset_det = 1'b1; reg_wr = 1'b1; reg_addr = 4'd3; reg_wdata = 32'h33;
    @(negedge clk);
    bus_reset_det = 1'b0; reg_wr = 1'b0;
    rd(4'd3, 32'h0, "R1 reset beats write");

    // R6 controller reset
    wr(4'd3, 32'h55);
    wr(4'd8, 32'h0);
    @(negedge clk); xfer_done = 32'h8; setup_rcvd = 16'h2;
    @(negedge clk); xfer_done = '0; setup_rcvd = '0;
    wr(4'd0, 32'h3);
    repeat (2) @(negedge clk);
    rd(4'd0, 32'h0, "R6 ctrl self cleared");
    rd(4'd3, 32'h0, "R6 addr reset");
    rd(4'd4, 32'h1, "R6 epen reset");
    rd(4'd2, 32'h0, "R6 ien reset");
    rd(4'd8, 32'h0, "R6 complete reset");
    rd(4'd5, 32'h0, "R6 setup reset");
    check("R6 run_stop low", {31'b0, run_stop}, 32'h0);

    // R11 unmapped
    rd(4'd15, 32'h0, "R11 unmapped");
    rd(4'd9, 32'h0, "R11 unmapped low");
    repeat (3) @(negedge clk);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule